// File: doc/BRIEF.md
# DDR Mode Register Programming Sequencer

This block lives inside a DDR SDRAM controller and turns one host request into the short series of load-mode-register commands that set the DLL state, the output drive strength and the operating bits (burst and latency) of the memory. The host presents the seven operating bits, a DLL-disable choice, a two-bit drive strength code and a relock flag, then pulses a request. The sequencer waits for the controller to report that every bank is idle. It then drives the command, bank-address and address pins in a fixed order, with the required spacing between writes.

A full sequence writes the extended register, then a base-register write with the DLL reset bit set, then a plain base-register write that returns the device to normal operation. A relock request is used after a clock frequency change. It skips the extended write and only resets the DLL before the normal write. Once the DLL has been enabled or reset, the block keeps its busy output high and its read-permit output low for a parameterised lock window. A request that asks for a reserved drive strength is refused with a one-cycle error pulse.

Top module: `ddr_mrs_seq`

## Requirements
- R1: After reset, busy, rd_ok and err are low, and the command pins carry a NOP: chip select low and row strobe, column strobe and write enable high (cs_n,ras_n,cas_n,we_n = 0,1,1,1).
- R2: When idle, a request whose drive code {E6,E1} is 2'b00 or 2'b10 and whose relock flag is low raises err for exactly the following cycle. busy stays low and no write is issued.
- R3: After a request is accepted, busy goes high and only NOP is driven until banks_idle is seen high. The first write comes in the cycle after the cycle in which banks_idle was sampled high.
- R4: An extended-register write is a load-mode command (all four command pins low) with bank address 2'b01 (BA0=1, BA1=0). Address bit 0 carries the DLL-disable choice (1 = disabled), bit 1 carries E1 (drive code bit 0) and bit 6 carries E6 (drive code bit 1). All other address bits are 0.
- R5: A DLL reset write is a load-mode command with bank address 2'b00, address bit 8 set, bits 7 and 9-11 clear, and the operating bits on address bits 6-0.
- R6: A normal-mode write is a load-mode command with bank address 2'b00, address bits 7-11 clear and the operating bits on bits 6-0.
- R7: A full request issues exactly three writes in the order extended, DLL reset, normal. Consecutive writes are TMRD cycles apart, so TMRD-1 NOP cycles lie between them (default TMRD = 2).
- R8: rd_ok is never high while busy is high. After a DLL reset write, busy falls and rd_ok rises exactly LOCK_CYC cycles later (default 200).
- R9: A relock request skips the extended write, issues a DLL reset write and then a normal write, and applies the R8 lock window. Its drive code is not checked.
- R10: A request with the DLL disabled issues the extended write and then the normal write, with no DLL reset write. busy falls TMRD cycles after the normal write, and rd_ok stays low afterwards.
- R11: A request pulse that arrives while busy has no effect. The running sequence keeps the operating bits it latched at the start.
- R12: Every cycle that does not carry a write carries a NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | One-cycle request pulse |
| req_op | input | OPW (7) | Operating bits for address 6-0 |
| req_dll_off | input | 1 | 1 = program the DLL as disabled |
| req_drive | input | 2 | Drive code {E6,E1}: 01 half, 11 matched |
| req_relock | input | 1 | 1 = DLL reset and normal write only |
| banks_idle | input | 1 | All banks idle, no burst running |
| busy | output | 1 | Sequence or lock window in progress |
| rd_ok | output | 1 | READ commands permitted |
| err | output | 1 | Pulse: request refused |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ba | output | 2 | Bank address, bit 0 = BA0 |
| mem_addr | output | AW (12) | Address pins |

## Verification
The assertions assume that banks_idle tells the truth and that TMRD is at least 2, so that two writes can never sit on adjacent cycles. They also assume the host only pulses req_valid, which the sequencer ignores while busy anyway. The stimulus asserts banks_idle only when no other traffic could exist, and it drives every request as a one-cycle pulse on a falling edge. The one deliberate out-of-sequence pulse is sent while busy is high, to show that the sequencer ignores it.

// File: rtl/mrs_pkg.sv
package mrs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_WAITBK = 3'd1,
        ST_EXT    = 3'd2,
        ST_DLLRST = 3'd3,
        ST_NORM   = 3'd4,
        ST_GAP    = 3'd5,
        ST_TAIL   = 3'd6
    } seq_st_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } cmd_t;

    localparam cmd_t CMD_NOP = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    localparam cmd_t CMD_LMR = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};

    localparam logic [1:0] BA_BASE = 2'b00;
    localparam logic [1:0] BA_EXT  = 2'b01;

    localparam int DLL_RST_BIT = 8;
    localparam int EXT_DLL_BIT = 0;
    localparam int EXT_DS_LO   = 1;
    localparam int EXT_DS_HI   = 6;

endpackage

// File: rtl/mrs_req_check.sv
module mrs_req_check (
    input  logic [1:0] drive,
    input  logic       relock,
    output logic       ok
);
    // Drive code {E6,E1}: only 01 and 11 are legal, i.e. E1 must be set.
    always_comb begin
        ok = relock | drive[0];
    end
endmodule

// File: rtl/mrs_word_build.sv
module mrs_word_build
    import mrs_pkg::*;
#(
    parameter int AW  = 12,
    parameter int OPW = 7
) (
    input  seq_st_e          st,
    input  logic [OPW-1:0]   op,
    input  logic             dll_off,
    input  logic [1:0]       drive,
    output cmd_t             cmd,
    output logic [1:0]       ba,
    output logic [AW-1:0]    addr
);
    always_comb begin
        cmd  = CMD_NOP;
        ba   = BA_BASE;
        addr = '0;
        unique case (st)
            ST_EXT: begin
                cmd                = CMD_LMR;
                ba                 = BA_EXT;
                addr[EXT_DLL_BIT]  = dll_off;
                addr[EXT_DS_LO]    = drive[0];
                addr[EXT_DS_HI]    = drive[1];
            end
            ST_DLLRST: begin
                cmd                = CMD_LMR;
                addr[OPW-1:0]      = op;
                addr[DLL_RST_BIT]  = 1'b1;
            end
            ST_NORM: begin
                cmd                = CMD_LMR;
                addr[OPW-1:0]      = op;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/mrs_lock_timer.sv
module mrs_lock_timer #(
    parameter int LOCK_CYC = 200,
    localparam int CW      = $clog2(LOCK_CYC + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    output logic [CW-1:0] remain
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (load)
            cnt_d = CW'(LOCK_CYC - 1);
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
        else
            cnt_d = cnt_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign remain = cnt_q;
endmodule

// File: rtl/ddr_mrs_seq.sv
module ddr_mrs_seq
    import mrs_pkg::*;
#(
    parameter int AW       = 12,
    parameter int OPW      = 7,
    parameter int TMRD     = 2,
    parameter int LOCK_CYC = 200
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [OPW-1:0]  req_op,
    input  logic            req_dll_off,
    input  logic [1:0]      req_drive,
    input  logic            req_relock,
    input  logic            banks_idle,
    output logic            busy,
    output logic            rd_ok,
    output logic            err,
    output logic            mem_cs_n,
    output logic            mem_ras_n,
    output logic            mem_cas_n,
    output logic            mem_we_n,
    output logic [1:0]      mem_ba,
    output logic [AW-1:0]   mem_addr
);
    localparam int GW = $clog2(TMRD + 1);
    localparam int CW = $clog2(LOCK_CYC + 1);
    localparam logic [GW-1:0] GAP_LOAD = GW'(TMRD - 1);

    typedef struct packed {
        seq_st_e        st;
        seq_st_e        after;
        logic [GW-1:0]  gap;
        logic [OPW-1:0] op;
        logic           dll_off;
        logic [1:0]     drive;
        logic           relock;
        logic           err;
        logic           cfg_done;
    } seq_t;

    seq_t          s_d, s_q;
    logic          req_ok;
    logic          lock_load;
    logic [CW-1:0] lock_left;
    cmd_t          cmd;

    mrs_req_check u_chk_req (
        .drive  (req_drive),
        .relock (req_relock),
        .ok     (req_ok)
    );

    mrs_lock_timer #(.LOCK_CYC(LOCK_CYC)) u_lock (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (lock_load),
        .remain (lock_left)
    );

    mrs_word_build #(.AW(AW), .OPW(OPW)) u_word (
        .st      (s_q.st),
        .op      (s_q.op),
        .dll_off (s_q.dll_off),
        .drive   (s_q.drive),
        .cmd     (cmd),
        .ba      (mem_ba),
        .addr    (mem_addr)
    );

    always_comb begin
        s_d       = s_q;
        s_d.err   = 1'b0;
        lock_load = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    if (!req_ok) begin
                        s_d.err = 1'b1;
                    end else begin
                        s_d.op       = req_op;
                        s_d.relock   = req_relock;
                        s_d.dll_off  = req_relock ? 1'b0 : req_dll_off;
                        s_d.drive    = req_drive;
                        s_d.cfg_done = 1'b0;
                        s_d.st       = ST_WAITBK;
                    end
                end
            end
            ST_WAITBK: begin
                if (banks_idle)
                    s_d.st = s_q.relock ? ST_DLLRST : ST_EXT;
            end
            ST_EXT: begin
                lock_load = !s_q.dll_off;
                s_d.gap   = GAP_LOAD;
                s_d.after = s_q.dll_off ? ST_NORM : ST_DLLRST;
                s_d.st    = (TMRD > 1) ? ST_GAP : s_d.after;
            end
            ST_DLLRST: begin
                lock_load = 1'b1;
                s_d.gap   = GAP_LOAD;
                s_d.after = ST_NORM;
                s_d.st    = (TMRD > 1) ? ST_GAP : ST_NORM;
            end
            ST_NORM: begin
                s_d.gap = GAP_LOAD;
                s_d.st  = ST_TAIL;
            end
            ST_GAP: begin
                if (s_q.gap != '0) s_d.gap = s_q.gap - 1'b1;
                if (s_q.gap <= GW'(1)) s_d.st = s_q.after;
            end
            ST_TAIL: begin
                if (s_q.gap != '0) s_d.gap = s_q.gap - 1'b1;
                if (s_q.gap <= GW'(1) && lock_left <= CW'(1)) begin
                    s_d.st       = ST_IDLE;
                    s_d.cfg_done = !s_q.dll_off;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy      = (s_q.st != ST_IDLE);
    assign rd_ok     = (s_q.st == ST_IDLE) && s_q.cfg_done;
    assign err       = s_q.err;
    assign mem_cs_n  = cmd.cs_n;
    assign mem_ras_n = cmd.ras_n;
    assign mem_cas_n = cmd.cas_n;
    assign mem_we_n  = cmd.we_n;
endmodule

// File: rtl/mrs_seq_chk.sv
module mrs_seq_chk #(
    parameter int AW   = 12,
    parameter int TMRD = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cs_n,
    input logic          ras_n,
    input logic          cas_n,
    input logic          we_n,
    input logic [1:0]    ba,
    input logic [AW-1:0] addr,
    input logic          busy,
    input logic          rd_ok,
    input logic          err
);
    logic lmr, nop;
    assign lmr = !cs_n && !ras_n && !cas_n && !we_n;
    assign nop = !cs_n && ras_n && cas_n && we_n;

    AST_EXT_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        (lmr && ba == 2'b01) |-> (addr[AW-1:7] == '0 && addr[5:2] == '0)); // R4

    AST_LEGAL_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        lmr |-> (ba == 2'b00 || ba == 2'b01)); // R4

    AST_BASE_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
        (lmr && ba == 2'b00) |-> (addr[AW-1:9] == '0 && !addr[7])); // R5

    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!busy && !lmr)); // R2

    AST_RD_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !rd_ok); // R8

    AST_IDLE_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> nop); // R12

    generate
        if (TMRD > 1) begin : g_gap
            AST_WRITE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
                lmr |=> !lmr); // R7
        end
    endgenerate
endmodule

bind ddr_mrs_seq mrs_seq_chk #(.AW(AW), .TMRD(TMRD)) u_seq_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .cs_n  (mem_cs_n),
    .ras_n (mem_ras_n),
    .cas_n (mem_cas_n),
    .we_n  (mem_we_n),
    .ba    (mem_ba),
    .addr  (mem_addr),
    .busy  (busy),
    .rd_ok (rd_ok),
    .err   (err)
);

// File: tb/ddr_mrs_seq_bench.sv
module ddr_mrs_seq_bench;
    localparam int TMRD = 2;
    localparam int LOCK = 200;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [6:0] req_op = '0;
    logic req_dll_off = 1'b0;
    logic [1:0] req_drive = 2'b11;
    logic req_relock = 1'b0;
    logic banks_idle = 1'b1;
    logic busy, rd_ok, err;
    logic cs_n, ras_n, cas_n, we_n;
    logic [1:0] ba;
    logic [11:0] addr;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    int n_w, end_cyc, nop_bad, rd_bad;
    logic end_rdok;
    logic [1:0] w_ba [4];
    logic [11:0] w_addr [4];
    int w_cyc [4];

    always #4 clk = ~clk;

    ddr_mrs_seq #(.AW(12), .OPW(7), .TMRD(TMRD), .LOCK_CYC(LOCK)) u_ddr_mrs_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_dll_off(req_dll_off), .req_drive(req_drive), .req_relock(req_relock),
        .banks_idle(banks_idle), .busy(busy), .rd_ok(rd_ok), .err(err),
        .mem_cs_n(cs_n), .mem_ras_n(ras_n), .mem_cas_n(cas_n), .mem_we_n(we_n),
        .mem_ba(ba), .mem_addr(addr)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            errors++;
            $display("FAIL watchdog: run hung, act cyc=%0d exp <100000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", rq, act, exp);
        end
    endtask

    function automatic logic [11:0] ext_word(input logic off, input logic [1:0] ds);
        ext_word = '0;
        ext_word[0] = off;
        ext_word[1] = ds[0];
        ext_word[6] = ds[1];
    endfunction

    // Issue a request pulse, then follow the pins until busy drops.
    task automatic run_seq(input logic [6:0] op, input logic off, input logic [1:0] ds,
                           input logic rl, input int release_at, input bit poke);
        @(negedge clk);
        req_op = op; req_dll_off = off; req_drive = ds; req_relock = rl;
        req_valid = 1'b1;
        n_w = 0; nop_bad = 0; rd_bad = 0; end_cyc = -1; end_rdok = 1'bx;
        for (int i = 1; i <= 1000; i++) begin
            @(negedge clk);
            if (i == 1) req_valid = 1'b0;
            if (i == release_at) banks_idle = 1'b1;
            if (poke && i == 4) begin req_valid = 1'b1; req_op = 7'h55; end
            if (poke && i == 5) req_valid = 1'b0;
            if ({cs_n, ras_n, cas_n, we_n} == 4'b0000) begin
                if (n_w < 4) begin
                    w_ba[n_w] = ba; w_addr[n_w] = addr; w_cyc[n_w] = i;
                end
                n_w++;
            end else if ({cs_n, ras_n, cas_n, we_n} != 4'b0111) begin
                nop_bad++;
            end
            if (busy && rd_ok) rd_bad++;
            if (!busy) begin
                end_cyc = i; end_rdok = rd_ok;
                break;
            end
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busy", busy, 0);
        chk("R1 rd_ok", rd_ok, 0);
        chk("R1 err", err, 0);
        chk("R1 nop", {cs_n, ras_n, cas_n, we_n}, 4'b0111);
    endtask

    task automatic t_reject(input logic [1:0] ds);
        int lmr_seen;
        lmr_seen = 0;
        @(negedge clk);
        req_op = 7'h11; req_dll_off = 1'b0; req_drive = ds; req_relock = 1'b0;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R2 err pulse", err, 1);
        chk("R2 busy low", busy, 0);
        @(negedge clk);
        chk("R2 err one cycle", err, 0);
        for (int i = 0; i < 5; i++) begin
            if ({cs_n, ras_n, cas_n, we_n} != 4'b0111 || busy) lmr_seen++;
            @(negedge clk);
        end
        chk("R2 nothing issued", lmr_seen, 0);
    endtask

    task automatic t_full_wait_banks();
        banks_idle = 1'b0;
        run_seq(7'h32, 1'b0, 2'b11, 1'b0, 5, 1'b0);
        chk("R3 first write after banks_idle", w_cyc[0], 6);
        chk("R7 write count", n_w, 3);
        chk("R4 ext bank", w_ba[0], 2'b01);
        chk("R4 ext word", w_addr[0], ext_word(1'b0, 2'b11));
        chk("R5 reset bank", w_ba[1], 2'b00);
        chk("R5 reset word", w_addr[1], 12'h100 | 12'h032);
        chk("R6 normal bank", w_ba[2], 2'b00);
        chk("R6 normal word", w_addr[2], 12'h032);
        chk("R7 gap ext-reset", w_cyc[1] - w_cyc[0], TMRD);
        chk("R7 gap reset-normal", w_cyc[2] - w_cyc[1], TMRD);
        chk("R8 lock window", end_cyc - w_cyc[1], LOCK);
        chk("R8 rd_ok after", end_rdok, 1);
        chk("R8 rd_ok while busy", rd_bad, 0);
        chk("R12 non-write NOP", nop_bad, 0);
    endtask

    task automatic t_dll_off();
        run_seq(7'h21, 1'b1, 2'b01, 1'b0, 0, 1'b0);
        chk("R10 write count", n_w, 2);
        chk("R10 ext bank", w_ba[0], 2'b01);
        chk("R10 ext word", w_addr[0], ext_word(1'b1, 2'b01));
        chk("R10 normal word", w_addr[1], 12'h021);
        chk("R10 normal bank", w_ba[1], 2'b00);
        chk("R10 busy end", end_cyc - w_cyc[1], TMRD);
        chk("R10 rd_ok stays low", end_rdok, 0);
        @(negedge clk);
        chk("R10 rd_ok later", rd_ok, 0);
    endtask

    task automatic t_relock();
        run_seq(7'h13, 1'b0, 2'b00, 1'b1, 0, 1'b0);
        chk("R9 write count", n_w, 2);
        chk("R9 first is reset", w_addr[0], 12'h113);
        chk("R9 reset bank", w_ba[0], 2'b00);
        chk("R9 first write cycle", w_cyc[0], 2);
        chk("R9 normal word", w_addr[1], 12'h013);
        chk("R9 lock window", end_cyc - w_cyc[0], LOCK);
        chk("R9 rd_ok after", end_rdok, 1);
        chk("R8 rd_ok while busy", rd_bad, 0);
        chk("R12 non-write NOP", nop_bad, 0);
    endtask

    task automatic t_busy_ignore();
        run_seq(7'h0A, 1'b0, 2'b01, 1'b0, 0, 1'b1);
        chk("R11 write count", n_w, 3);
        chk("R11 ext word", w_addr[0], ext_word(1'b0, 2'b01));
        chk("R11 reset keeps op", w_addr[1], 12'h10A);
        chk("R11 normal keeps op", w_addr[2], 12'h00A);
        @(negedge clk);
        chk("R11 no restart", busy, 0);
    endtask

    initial begin
        t_reset();
        t_reject(2'b00);
        t_reject(2'b10);
        t_full_wait_banks();
        t_dll_off();
        t_relock();
        t_busy_ignore();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule